// File: doc/BRIEF.md
# Time-Slotted Shared Bus Arbiter with Reserved Slots

This block decides which of N nodes owns a shared on-chip bus. Time is cut into slots of a programmable number of clock cycles, and sixteen consecutive slots form a frame that repeats without end. While a slot runs, every node that wants the bus holds its request line high. When the slot ends, the arbiter issues a one-hot grant that holds for the whole of the following slot. Only one node ever drives the bus at a time.

A reservation table has one entry per slot of the frame. Each entry is either empty or names a node that owns that slot. A reserved slot goes to its owner whenever the owner asked for it during the slot before. This gives each owner a fixed share of the bandwidth. A slot that is not reserved, or whose owner did not ask, goes to the other requesters in round-robin order. Software writes the table through a one-entry-per-cycle write port.

Top module: `tdm_slot_arbiter`

## Requirements
- R1: While reset is held and right after it, the grant is all zero, the current slot number is 0 and every table entry is empty.
- R2: A slot lasts exactly `slot_len` clock cycles. The slot number then steps by one and goes from 15 back to 0.
- R3: A `slot_len` of 0 is treated as 1, so that every clock edge ends a slot.
- R4: The requests seen in any cycle of a slot, OR-ed together, decide the grant for the next slot. The grant changes only on the clock edge that ends a slot.
- R5: If no node asked during a slot, the grant for the next slot is all zero.
- R6: If the table entry for the next slot is valid and names node k, and node k asked during the current slot, node k gets the next slot whatever the other nodes ask.
- R7: If the next slot is reserved but its owner did not ask, the slot is handed out by round robin among the nodes that did ask.
- R8: Round robin searches upward from a pointer, wrapping from N-1 to 0, and grants the first requester it finds. The pointer starts at 0 and becomes the winner's index plus one (modulo N) only after a round-robin grant. Reserved grants leave the pointer unchanged.
- R9: A write with `tbl_we` high stores `tbl_valid` and `tbl_node` into the entry at `tbl_addr`. The new entry is used from the next clock edge on. Writing valid 0 frees the slot for round robin.
- R10: The grant always has at most one bit set, and bit k means node k owns the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_len | input | LEN_W (8) | Cycles per slot (0 acts as 1) |
| req | input | N_NODES (4) | Bus request, one bit per node |
| tbl_we | input | 1 | Reservation table write enable |
| tbl_addr | input | SLOT_W (4) | Slot number of the entry to write |
| tbl_valid | input | 1 | Valid bit to store |
| tbl_node | input | IDX_W (2) | Owner node index to store |
| grant | output | N_NODES (4) | One-hot bus ownership for the current slot |
| slot_num | output | SLOT_W (4) | Number of the slot now running |

## Verification
The assertions assume that every owner index written into the table names an existing node. They also assume that `slot_len` only changes in the first cycle of a slot, so that a slot is never cut short part-way through. The stimulus follows both rules. It holds each request pattern steady for a whole slot, changes `slot_len` only in the cycle right after a slot ends, and places table writes in slots of two or more cycles. This way the slot in which a new entry first applies is known without doubt.

// File: rtl/tdm_arb_pkg.sv
package tdm_arb_pkg;

  // Index of the first set bit found searching upward from start, wrapping
  // at n; -1 when no bit of the lower n bits is set.
  function automatic int rr_first(input logic [63:0] mask, input int start, input int n);
    int hit;
    hit = -1;
    for (int k = 0; k < n; k++) begin
      int idx;
      idx = (start + k) % n;
      if (hit < 0 && mask[idx]) hit = idx;
    end
    return hit;
  endfunction

  // Position that follows a winner, wrapping at n.
  function automatic int next_pos(input int win, input int n);
    return (win + 1 >= n) ? 0 : win + 1;
  endfunction

endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
  parameter int LEN_W = 8,
  parameter int SLOTS = 16,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  slot_len,
  output logic              slot_edge,
  output logic [SLOT_W-1:0] slot_num,
  output logic [SLOT_W-1:0] next_slot
);
  logic [LEN_W-1:0] cyc;
  logic [LEN_W-1:0] eff_len;

  assign eff_len   = (slot_len == '0) ? LEN_W'(1) : slot_len;
  assign slot_edge = (cyc >= eff_len - LEN_W'(1));
  assign next_slot = (slot_num == SLOT_W'(SLOTS - 1)) ? '0 : slot_num + SLOT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc      <= '0;
      slot_num <= '0;
    end else if (slot_edge) begin
      cyc      <= '0;
      slot_num <= next_slot;
    end else begin
      cyc <= cyc + LEN_W'(1);
    end
  end

  // R2
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_edge |=> $stable(slot_num));

  // R2
  slot_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_edge |=> (cyc == '0));

endmodule

// File: rtl/tdm_resv_table.sv
module tdm_resv_table #(
  parameter int SLOTS = 16,
  parameter int IDX_W = 2,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_addr,
  input  logic              wr_valid,
  input  logic [IDX_W-1:0]  wr_node,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic              rd_valid,
  output logic [IDX_W-1:0]  rd_node
);
  logic [SLOTS-1:0] ent_valid;
  logic [IDX_W-1:0] ent_node [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_valid[g] <= 1'b0;
        ent_node[g]  <= '0;
      end else if (wr_en && wr_addr == SLOT_W'(g)) begin
        ent_valid[g] <= wr_valid;
        ent_node[g]  <= wr_node;
      end
    end
  end

  assign rd_valid = ent_valid[rd_slot];
  assign rd_node  = ent_node[rd_slot];

  // R9
  tbl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == rd_slot) |=> (rd_slot != $past(rd_slot)) ||
      (rd_valid == $past(wr_valid)));

endmodule

// File: rtl/tdm_rr_picker.sv
module tdm_rr_picker #(
  parameter int N_NODES = 4,
  parameter int IDX_W = $clog2(N_NODES)
) (
  input  logic [N_NODES-1:0] mask,
  input  logic [IDX_W-1:0]   ptr,
  output logic               hit,
  output logic [IDX_W-1:0]   win,
  output logic [IDX_W-1:0]   ptr_next
);
  import tdm_arb_pkg::*;

  int pick;

  always_comb begin
    pick     = rr_first(64'(mask), int'(ptr), N_NODES);
    hit      = (pick >= 0);
    win      = hit ? IDX_W'(pick) : '0;
    ptr_next = hit ? IDX_W'(next_pos(pick, N_NODES)) : ptr;
  end

endmodule

// File: rtl/tdm_slot_arbiter.sv
module tdm_slot_arbiter #(
  parameter int N_NODES = 4,
  parameter int SLOTS = 16,
  parameter int LEN_W = 8,
  parameter int IDX_W = $clog2(N_NODES),
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LEN_W-1:0]   slot_len,
  input  logic [N_NODES-1:0] req,
  input  logic               tbl_we,
  input  logic [SLOT_W-1:0]  tbl_addr,
  input  logic               tbl_valid,
  input  logic [IDX_W-1:0]   tbl_node,
  output logic [N_NODES-1:0] grant,
  output logic [SLOT_W-1:0]  slot_num
);
  logic               slot_edge;
  logic [SLOT_W-1:0]  next_slot;
  logic               rsv_valid;
  logic [IDX_W-1:0]   rsv_node;
  logic [N_NODES-1:0] req_acc;
  logic [N_NODES-1:0] req_all;
  logic [IDX_W-1:0]   rr_ptr;
  logic               rr_hit;
  logic [IDX_W-1:0]   rr_win;
  logic [IDX_W-1:0]   rr_ptr_next;
  logic               owner_asks;
  logic [N_NODES-1:0] grant_next;

  tdm_slot_timer #(.LEN_W(LEN_W), .SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_len  (slot_len),
    .slot_edge (slot_edge),
    .slot_num  (slot_num),
    .next_slot (next_slot)
  );

  tdm_resv_table #(.SLOTS(SLOTS), .IDX_W(IDX_W), .SLOT_W(SLOT_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (tbl_we),
    .wr_addr  (tbl_addr),
    .wr_valid (tbl_valid),
    .wr_node  (tbl_node),
    .rd_slot  (next_slot),
    .rd_valid (rsv_valid),
    .rd_node  (rsv_node)
  );

  tdm_rr_picker #(.N_NODES(N_NODES), .IDX_W(IDX_W)) u_rr (
    .mask     (req_all),
    .ptr      (rr_ptr),
    .hit      (rr_hit),
    .win      (rr_win),
    .ptr_next (rr_ptr_next)
  );

  assign req_all    = req_acc | req;
  assign owner_asks = rsv_valid && req_all[rsv_node];

  always_comb begin
    if (owner_asks)  grant_next = N_NODES'(1) << rsv_node;
    else if (rr_hit) grant_next = N_NODES'(1) << rr_win;
    else             grant_next = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant   <= '0;
      req_acc <= '0;
      rr_ptr  <= '0;
    end else if (slot_edge) begin
      grant   <= grant_next;
      req_acc <= '0;
      if (!owner_asks) rr_ptr <= rr_ptr_next;
    end else begin
      req_acc <= req_all;
    end
  end

  // R10
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R4
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_edge |=> $stable(grant));

  // R5
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_edge && req_all == '0) |=> (grant == '0));

  // R6
  resv_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_edge && owner_asks) |=> (grant == (N_NODES'(1) << $past(rsv_node))));

  // R8
  resv_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_edge && owner_asks) |=> $stable(rr_ptr));

  // R4
  grant_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_edge |=> ((grant & $past(req_all)) == grant));

endmodule

// File: tb/test_tdm_slot_arbiter.sv
`timescale 1ns/1ps
module test_tdm_slot_arbiter;
  localparam int N = 4;
  localparam int S = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] slot_len = 8'd3;
  logic [3:0] req = '0;
  logic       tbl_we = 1'b0;
  logic [3:0] tbl_addr = '0;
  logic       tbl_valid = 1'b0;
  logic [1:0] tbl_node = '0;
  logic [3:0] grant;
  logic [3:0] slot_num;

  always #5 clk = ~clk;

  tdm_slot_arbiter i_tdm_slot_arbiter (
    .clk(clk), .rst_n(rst_n), .slot_len(slot_len), .req(req),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_valid(tbl_valid),
    .tbl_node(tbl_node), .grant(grant), .slot_num(slot_num)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  bit m_valid [S];
  int m_node [S];
  int m_ptr = 0;
  int m_cur = 0;
  int m_len = 3;

  int    q_grant [$];
  int    q_slot [$];
  string q_tag [$];
  event  mon_ev;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expect_grant(input logic [3:0] mask, input int nx);
    if (m_valid[nx] && mask[m_node[nx]]) return 1 << m_node[nx];
    for (int k = 0; k < N; k++) begin
      int i;
      i = (m_ptr + k) % N;
      if (mask[i]) begin
        m_ptr = (i + 1) % N;
        return 1 << i;
      end
    end
    return 0;
  endfunction

  // driver: one whole slot, optional table write in its first cycle
  task automatic drive_slot(input logic [3:0] mask, input string tag,
                            input bit wr = 0, input int wa = 0,
                            input bit wv = 0, input int wn = 0);
    int el;
    logic [3:0] prev;
    int nx;
    el = (m_len == 0) ? 1 : m_len;
    req = mask;
    if (wr) begin
      tbl_we = 1'b1; tbl_addr = 4'(wa); tbl_valid = wv; tbl_node = 2'(wn);
      m_valid[wa] = wv; m_node[wa] = wn;
    end
    prev = grant;
    for (int i = 0; i < el; i++) begin
      @(posedge clk); #1;
      tbl_we = 1'b0;
      if (i < el - 1) check(grant == prev, {"R4 mid-slot hold ", tag}, grant, prev);
    end
    nx = (m_cur + 1) % S;
    q_grant.push_back(expect_grant(mask, nx));
    q_slot.push_back(nx);
    q_tag.push_back(tag);
    m_cur = nx;
    -> mon_ev;
    @(negedge clk);
  endtask

  // monitor: compare design output against queued expectations
  initial begin
    forever begin
      @(mon_ev);
      while (q_grant.size() > 0) begin
        int eg, es;
        string t;
        eg = q_grant.pop_front();
        es = q_slot.pop_front();
        t = q_tag.pop_front();
        check(grant == 4'(eg), {t, " grant"}, grant, eg);
        check(slot_num == 4'(es), {"R2 slot number ", t}, slot_num, es);
      end
    end
  end

  task automatic set_len(input int l);
    slot_len = 8'(l);
    m_len = l;
  endtask

  initial begin
    for (int i = 0; i < S; i++) begin m_valid[i] = 0; m_node[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    check(grant == 0, "R1 reset grant", grant, 0);
    check(slot_num == 0, "R1 reset slot", slot_num, 0);
    @(negedge clk);
    rst_n = 1'b1;
    check(grant == 0, "R1 after reset grant", grant, 0);

    drive_slot(4'b0000, "R5 idle");
    for (int i = 0; i < 5; i++) drive_slot(4'b1111, "R8 rotate all");
    drive_slot(4'b0101, "R8 skip to next asker");
    drive_slot(4'b0101, "R8 wrap");
    drive_slot(4'b1011, "R6 owner wins", 1, (m_cur + 1) % S, 1, 3);
    drive_slot(4'b1111, "R8 pointer kept after reserve");
    drive_slot(4'b0011, "R7 owner absent", 1, (m_cur + 1) % S, 1, 2);
    drive_slot(4'b0000, "R5 idle reserved slot");
    for (int i = 0; i < 8; i++) drive_slot(4'b1111, "R6 R7 wrap frame");
    drive_slot(4'b1111, "R9 entry cleared", 1, (m_cur + 1) % S, 0, 0);
    drive_slot(4'b0010, "R8 single asker");
    for (int i = 0; i < 4; i++) drive_slot(4'b1110, "R2 frame loop");

    set_len(1);
    drive_slot(4'b1000, "R2 len one");
    drive_slot(4'b0000, "R5 len one idle");
    drive_slot(4'b0110, "R8 len one");
    set_len(0);
    for (int i = 0; i < 6; i++) drive_slot(4'(i + 3), "R3 len zero");
    set_len(5);
    drive_slot(4'b1100, "R2 len five");
    drive_slot(4'b1000, "R6 owner alone", 1, (m_cur + 1) % S, 1, 3);
    drive_slot(4'b0100, "R10 one hot");
    for (int i = 0; i < 20; i++) drive_slot(4'(i * 7), "R4 mixed");

    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule